// File: doc/BRIEF.md
# On-Screen Display Memory Word Interpreter

This block holds the 64-word by 10-bit character memory of an on-screen display and walks it in address order, one word per `step` request from the raster timing logic. Each word carries a 6-bit code and a 4-bit attribute. The code selects a font character, a line-break code or a blank-cell code, and the attribute is read differently for each of the three. The block hands the character generator the font index and the foreground colour of the current word. It keeps the next-line dot size, the line gap and the background colour taken from the most recent control codes, and it raises an end-of-display flag when the walk is over.

A processor-side write port stores words at an internal address. The address advances by one after every write and can be reloaded at any time. A frame counter advances on each rising edge of vertical sync and drives a blink phase with a selectable period and on/off duty. Characters marked for blinking lose their foreground colour during the dark part of the phase.

Top module: `osd_code_interp`

## Requirements
- R1: After reset `rd_addr`, `wr_addr`, `eod`, `line_size`, `line_gap` and `bg_rgb` are 0, and the frame count is 0.
- R2: `code_kind` reports 0 for codes 0x00..0x3D, 1 for 0x3E (line break) and 2 for 0x3F (blank cell), where the code is bits 9..4 of the word at `rd_addr`. `font_idx` equals the code for a character and is 0 otherwise.
- R3: For a character word that is not blinking (bit 0 = 0), `fg_rgb` = {bit3 red, bit2 green, bit1 blue}, in that order from MSB to LSB. For any other code, `fg_rgb` is 0.
- R4: Let F be the number of vertical-sync rising edges since reset, modulo 128, and P = 16 << `blink_rate`. With pos = F mod P, `blink_lit` is 1 exactly when pos < P/4 (`blink_duty`=1), pos < 3P/4 (`blink_duty`=2), or pos < P/2 (`blink_duty`=0 or 3).
- R5: A character word with bit 0 = 1 drives `fg_rgb` to 0 while `blink_lit` is 0 and to its colour while `blink_lit` is 1.
- R6: A step over a line-break word loads `line_size` from bits 3..2 and `line_gap` with 4 × bits 1..0 (0, 4, 8 or 12 scan lines).
- R7: A step over a blank-cell word loads `bg_rgb` from bits 3..1.
- R8: A step advances `rd_addr` by 1. A step over a blank-cell word whose bit 0 is 1, or a step at address 63, sets `eod` instead and leaves `rd_addr` unchanged.
- R9: While `eod` is 1, steps change neither `rd_addr` nor the latched attributes, and `fg_rgb` and `font_idx` are 0.
- R10: A rising edge of `vsync` sets `rd_addr` to 0, clears `eod`, `line_size`, `line_gap` and `bg_rgb`, and advances the frame count. It takes precedence over a step in the same cycle.
- R11: `wr_en` stores `wr_data` at `wr_addr` and increments `wr_addr`, wrapping from 63 to 0. `addr_load` places `addr_in` in `wr_addr`. When both are high, the word goes to `addr_in` and `wr_addr` becomes `addr_in`+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Store `wr_data` and post-increment the write address |
| addr_load | input | 1 | Load the write address from `addr_in` |
| addr_in | input | 6 | New write address |
| wr_data | input | 10 | Word to store: code in bits 9..4, attribute in bits 3..0 |
| vsync | input | 1 | Vertical sync, active high; the rising edge starts a frame |
| step | input | 1 | Consume the current word and move to the next |
| blink_rate | input | 2 | Blink period select: 16, 32, 64 or 128 frames |
| blink_duty | input | 2 | Blink duty: 0 and 3 give 1:1, 1 gives 1:3, 2 gives 3:1 (on:off) |
| rd_addr | output | 6 | Address of the current word |
| wr_addr | output | 6 | Current write address |
| code_kind | output | 2 | 0 character, 1 line break, 2 blank cell |
| font_idx | output | 6 | Font index of the current character |
| fg_rgb | output | 3 | Gated foreground colour {R,G,B} |
| blink_lit | output | 1 | Blink phase is in its lit part |
| bg_rgb | output | 3 | Background colour from the last blank cell |
| line_size | output | 2 | Dot size for the next line: 0..3 gives 1x..4x |
| line_gap | output | 4 | Scan lines between text lines |
| eod | output | 1 | End of display reached |

## Verification
The assertions assume that `step` is used only between frames started by a `vsync` rising edge. They also assume that memory words are written before they are stepped over, so the decoded code is never unknown at a checked step. The stimulus writes all 64 words before the first frame and rewrites words only at points where the expected model is updated at the same time. Each input is held for whole clock cycles and driven away from the active edge. `vsync` and `step` are never raised together, except where the bench tests that the frame start takes precedence.

// File: rtl/osd_pkg.sv
package osd_pkg;
  localparam int CODE_W = 6;
  localparam int ATTR_W = 4;
  localparam int WORD_W = CODE_W + ATTR_W;
  localparam int FCNT_W = 7;

  localparam logic [CODE_W-1:0] CODE_BREAK = 6'h3E;
  localparam logic [CODE_W-1:0] CODE_BLANK = 6'h3F;

  typedef enum logic [1:0] {
    KIND_CHAR  = 2'd0,
    KIND_BREAK = 2'd1,
    KIND_BLANK = 2'd2
  } kind_e;

  function automatic kind_e classify(input logic [CODE_W-1:0] code);
    if (code == CODE_BLANK)      return KIND_BLANK;
    else if (code == CODE_BREAK) return KIND_BREAK;
    else                         return KIND_CHAR;
  endfunction

  // lit part of the blink cycle: period 16 << rate frames
  function automatic logic blink_phase(input logic [FCNT_W-1:0] fcnt,
                                       input logic [1:0] rate,
                                       input logic [1:0] duty);
    logic [FCNT_W:0] period;
    logic [FCNT_W:0] pos;
    logic [FCNT_W:0] limit;
    period = (FCNT_W+1)'(16) << rate;
    pos    = {1'b0, fcnt} & (period - 1'b1);
    case (duty)
      2'd1:    limit = period >> 2;
      2'd2:    limit = period - (period >> 2);
      default: limit = period >> 1;
    endcase
    return pos < limit;
  endfunction

  function automatic logic [3:0] gap_lines(input logic [1:0] sel);
    return {sel, 2'b00};
  endfunction
endpackage

// File: rtl/osd_wr_port.sv
module osd_wr_port #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] wr_target
);
  assign wr_target = addr_load ? addr_in : wr_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wr_addr <= '0;
    else if (wr_en)   wr_addr <= wr_target + 1'b1;
    else if (addr_load) wr_addr <= addr_in;
  end

  AST_WR_POSTINC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_load) |=> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1))); // R11
  AST_WR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_load && (&wr_addr)) |=> (wr_addr == '0)); // R11
  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_load && !wr_en) |=> (wr_addr == $past(addr_in))); // R11
endmodule

// File: rtl/osd_blink.sv
module osd_blink
  import osd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [1:0]        rate,
  input  logic [1:0]        duty,
  output logic [FCNT_W-1:0] fcnt,
  output logic              lit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           fcnt <= '0;
    else if (frame_start) fcnt <= fcnt + 1'b1;
  end

  assign lit = blink_phase(fcnt, rate, duty);

  AST_FRAME_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (fcnt == FCNT_W'($past(fcnt) + 1'b1))); // R10
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(fcnt)); // R4
endmodule

// File: rtl/osd_reader.sv
module osd_reader #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              step,
  input  logic              end_word,
  output logic [ADDR_W-1:0] ptr,
  output logic              done,
  output logic              take
);
  logic last_slot;

  assign take      = step && !done && !frame_start;
  assign last_slot = (&ptr) || end_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      done <= 1'b0;
    end else if (frame_start) begin
      ptr  <= '0;
      done <= 1'b0;
    end else if (take) begin
      if (last_slot) done <= 1'b1;
      else           ptr  <= ptr + 1'b1;
    end
  end

  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (ptr == '0 && !done)); // R10
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !frame_start) |=> (done && $stable(ptr))); // R9
  AST_STEP_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !last_slot) |=> (ptr == ADDR_W'($past(ptr) + 1'b1))); // R8
  AST_LAST_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last_slot) |=> (done && $stable(ptr))); // R8
endmodule

// File: rtl/osd_code_interp.sv
module osd_code_interp
  import osd_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [9:0]        wr_data,
  input  logic              vsync,
  input  logic              step,
  input  logic [1:0]        blink_rate,
  input  logic [1:0]        blink_duty,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [1:0]        code_kind,
  output logic [5:0]        font_idx,
  output logic [2:0]        fg_rgb,
  output logic              blink_lit,
  output logic [2:0]        bg_rgb,
  output logic [1:0]        line_size,
  output logic [3:0]        line_gap,
  output logic              eod
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wr_target;
  logic              vsync_q;
  logic              frame_start;
  logic              take;
  logic              end_word;
  logic [FCNT_W-1:0] fcnt;
  logic [WORD_W-1:0] cur_word;
  logic [CODE_W-1:0] cur_code;
  logic [ATTR_W-1:0] cur_attr;
  kind_e             cur_kind;
  logic              show_fg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vsync_q <= 1'b0;
    else        vsync_q <= vsync;
  end
  assign frame_start = vsync && !vsync_q;

  osd_wr_port #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_load(addr_load),
    .addr_in(addr_in), .wr_addr(wr_addr), .wr_target(wr_target)
  );

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_target] <= wr_data;
  end

  osd_blink u_blink (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .rate(blink_rate), .duty(blink_duty), .fcnt(fcnt), .lit(blink_lit)
  );

  assign cur_word = mem[rd_addr];
  assign cur_code = cur_word[WORD_W-1:ATTR_W];
  assign cur_attr = cur_word[ATTR_W-1:0];
  assign cur_kind = classify(cur_code);
  assign end_word = (cur_kind == KIND_BLANK) && cur_attr[0];

  osd_reader #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .step(step),
    .end_word(end_word), .ptr(rd_addr), .done(eod), .take(take)
  );

  // latched per-line and per-word attributes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bg_rgb    <= '0;
      line_size <= '0;
      line_gap  <= '0;
    end else if (frame_start) begin
      bg_rgb    <= '0;
      line_size <= '0;
      line_gap  <= '0;
    end else if (take) begin
      if (cur_kind == KIND_BLANK) bg_rgb <= cur_attr[3:1];
      if (cur_kind == KIND_BREAK) begin
        line_size <= cur_attr[3:2];
        line_gap  <= gap_lines(cur_attr[1:0]);
      end
    end
  end

  assign show_fg   = !eod && (cur_kind == KIND_CHAR) && (!cur_attr[0] || blink_lit);
  assign code_kind = cur_kind;
  assign font_idx  = (!eod && cur_kind == KIND_CHAR) ? cur_code : '0;
  assign fg_rgb    = show_fg ? cur_attr[3:1] : 3'b000;

  AST_DARK_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    eod |-> (fg_rgb == 3'b000 && font_idx == '0)); // R9
  AST_ATTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (eod && !frame_start) |=> ($stable(bg_rgb) && $stable(line_size) && $stable(line_gap))); // R9
  AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (bg_rgb == '0 && line_size == '0 && line_gap == '0)); // R10
  AST_GAP_STEP4: assert property (@(posedge clk) disable iff (!rst_n)
    line_gap[1:0] == 2'b00); // R6
  AST_BLINK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (!blink_lit && cur_kind == KIND_CHAR && cur_attr[0]) |-> (fg_rgb == 3'b000)); // R5
endmodule

// File: tb/test_osd_code_interp.sv
module test_osd_code_interp;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, addr_load = 1'b0, vsync = 1'b0, step = 1'b0;
  logic [5:0] addr_in = '0;
  logic [9:0] wr_data = '0;
  logic [1:0] blink_rate = '0, blink_duty = '0;
  logic [5:0] rd_addr, wr_addr, font_idx;
  logic [1:0] code_kind, line_size;
  logic [2:0] fg_rgb, bg_rgb;
  logic [3:0] line_gap;
  logic       blink_lit, eod;

  int nvec = 0, nbad = 0;
  int frames = 0;
  logic [9:0] model [64];
  logic       done_flag = 1'b0;

  always #4 clk = ~clk;

  osd_code_interp i_osd_code_interp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_load(addr_load),
    .addr_in(addr_in), .wr_data(wr_data), .vsync(vsync), .step(step),
    .blink_rate(blink_rate), .blink_duty(blink_duty), .rd_addr(rd_addr),
    .wr_addr(wr_addr), .code_kind(code_kind), .font_idx(font_idx),
    .fg_rgb(fg_rgb), .blink_lit(blink_lit), .bg_rgb(bg_rgb),
    .line_size(line_size), .line_gap(line_gap), .eod(eod)
  );

  task automatic chk(input int got, input int exp, input string tag);
    nvec++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int exp_lit(input int f, input int rate, input int duty);
    int period = 16 * (2 ** rate);
    int pos = (f % 128) % period;
    if (duty == 1) return (4 * pos < period) ? 1 : 0;
    if (duty == 2) return (4 * pos < 3 * period) ? 1 : 0;
    return (2 * pos < period) ? 1 : 0;
  endfunction

  task automatic write_word(input int a, input logic [9:0] w, input bit load);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w; addr_load = load; addr_in = 6'(a);
    @(negedge clk);
    wr_en = 1'b0; addr_load = 1'b0;
    model[a] = w;
  endtask

  task automatic frame();
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); vsync = 1'b0;
    frames++;
  endtask

  task automatic do_step();
    @(negedge clk); step = 1'b1;
    @(negedge clk); step = 1'b0;
  endtask

  // check the combinational decode of the word at address a
  task automatic chk_word(input int a, input bit ended);
    int code = int'(model[a][9:4]);
    int kind = (code == 63) ? 2 : (code == 62) ? 1 : 0;
    int lit  = exp_lit(frames, int'(blink_rate), int'(blink_duty));
    int fg   = 0;
    if (!ended && kind == 0 && (model[a][0] == 1'b0 || lit == 1)) fg = int'(model[a][3:1]);
    chk(code_kind, kind, "R2 kind");
    chk(font_idx, (!ended && kind == 0) ? code : 0, "R2 font index");
    if (model[a][0]) chk(fg_rgb, fg, "R5 blink gated colour");
    else             chk(fg_rgb, fg, "R3 colour");
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int ebg, esz, egap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rd_addr, 0, "R1 rd_addr"); chk(wr_addr, 0, "R1 wr_addr");
    chk(eod, 0, "R1 eod"); chk(bg_rgb, 0, "R1 bg");
    chk(line_size, 0, "R1 size"); chk(line_gap, 0, "R1 gap");
    chk(blink_lit, 1, "R1 frame count zero gives lit");

    // R11 sequential fill with post-increment, then wrap
    for (int i = 0; i < 64; i++) begin
      write_word(i, {6'(i), 4'((i * 5 + 3) & 15)}, 1'b0);
      chk(wr_addr, (i + 1) % 64, "R11 post increment");
    end

    // full walk of one frame
    frame();
    chk(rd_addr, 0, "R10 frame start");
    ebg = 0; esz = 0; egap = 0;
    for (int a = 0; a < 64; a++) begin
      chk(rd_addr, a, "R8 address");
      chk_word(a, 1'b0);
      if (model[a][9:4] == 6'h3F) ebg = int'(model[a][3:1]);
      if (model[a][9:4] == 6'h3E) begin esz = int'(model[a][3:2]); egap = 4 * int'(model[a][1:0]); end
      do_step();
      chk(bg_rgb, ebg, "R7 background");
      chk(line_size, esz, "R6 size");
      chk(line_gap, egap, "R6 gap");
    end
    chk(eod, 1, "R8 end at last address");
    chk(rd_addr, 63, "R8 hold at last address");
    chk_word(63, 1'b1);
    do_step();
    chk(rd_addr, 63, "R9 step ignored after end");
    chk(bg_rgb, ebg, "R9 bg frozen");

    // rewrite with loaded addresses: break with size 2 gap 12, blank with end bit
    write_word(3, {6'h3E, 4'b1011}, 1'b1);
    chk(wr_addr, 4, "R11 load then increment");
    write_word(4, {6'h3F, 4'b1010}, 1'b0);
    write_word(9, {6'h3F, 4'b1011}, 1'b1);
    chk(wr_addr, 10, "R11 load address");
    @(negedge clk); addr_load = 1'b1; addr_in = 6'd40;
    @(negedge clk); addr_load = 1'b0;
    chk(wr_addr, 40, "R11 load without write");
    write_word(63, 10'h000, 1'b1);
    chk(wr_addr, 0, "R11 wrap after load");

    frame();
    chk(eod, 0, "R10 end cleared");
    chk(bg_rgb, 0, "R10 bg cleared"); chk(line_gap, 0, "R10 gap cleared");
    for (int a = 0; a < 10; a++) do_step();
    chk(line_size, 2, "R6 loaded size");
    chk(line_gap, 12, "R6 loaded gap");
    chk(bg_rgb, 5, "R7 end word colour");
    chk(eod, 1, "R8 end word");
    chk(rd_addr, 9, "R8 end word holds address");
    chk(fg_rgb, 0, "R9 dark after end");

    // frame start wins over a simultaneous step
    @(negedge clk); vsync = 1'b1; step = 1'b1;
    @(negedge clk); vsync = 1'b0; step = 1'b0;
    frames++;
    chk(rd_addr, 0, "R10 precedence");
    chk(eod, 0, "R10 precedence end");

    // blink sweep: word 0 blinking white character, word 1 steady
    write_word(0, {6'd5, 4'b1111}, 1'b1);
    write_word(1, {6'd7, 4'b0110}, 1'b0);
    for (int r = 0; r < 4; r++) begin
      for (int d = 0; d < 4; d++) begin
        @(negedge clk); blink_rate = 2'(r); blink_duty = 2'(d);
        for (int f = 0; f < 130; f++) begin
          frame();
          chk(blink_lit, exp_lit(frames, r, d), "R4 blink phase");
          chk(fg_rgb, exp_lit(frames, r, d) * 7, "R5 blink gate");
        end
      end
    end
    do_step();
    chk_word(1, 1'b0);
    chk(fg_rgb, 3, "R3 steady colour unaffected by blink");

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule